// File: doc/BRIEF.md
# Periodic Countdown Tick Timer

A down-counting tick timer with a 32-bit register interface. Software loads a reload value, turns the timer on, and then gets a periodic event each time the count passes from one to zero. The counter steps either on every core clock or on a one-cycle reference tick enable input. A control bit picks which. Each expiry sets a sticky flag that software can poll. If interrupts are enabled, expiry also sends a one-cycle request pulse to an external interrupt controller.

The register space holds four words: control/status, reload value, current value and a read-only calibration constant. Reads are registered, and the data returns one cycle after the read strobe. Reading the control word also clears the sticky flag. Writing the current-value word, whatever the data, restarts the period. A reload value of zero turns the timer into a one-shot that switches itself off on expiry.

Top module: `tick_timer`

## Requirements
- R1: After the synchronous active-high reset, the control, reload and current-value words read as zero and `irq_pulse` is low.
- R2: Control word at offset 0x0: bit 0 = run enable, bit 1 = interrupt enable, bit 2 = step source (1 core clock, 0 `ref_tick`), bit 16 = sticky expiry flag, all other bits read zero. A write changes only bits [2:0].
- R3: Read data appears on `rd_data` one cycle after `rd_en`. A read of the control word returns the flag and then clears it. An expiry in the same cycle as the read keeps the flag set.
- R4: While enabled, the count drops by one per step event. A step event is every clock when bit 2 = 1, and every cycle with `ref_tick` high when bit 2 = 0. A step at zero loads the reload value, so one period is reload+1 events.
- R5: A step from 1 to 0 is an expiry. It sets the flag. When the interrupt enable is 1, it also raises `irq_pulse` for exactly the following cycle. When the interrupt enable is 0, the flag is still set but `irq_pulse` stays low.
- R6: An expiry with a reload value of zero clears the run enable, and counting stops.
- R7: A write to the current-value word (offset 0x8), with any data, loads the count from the reload value and clears the flag, whether or not the timer runs.
- R8: The current-value word reads zero while the run enable is 0, and the count is held through a disabled period.
- R9: The calibration word (offset 0xC) reads the constant 10000, and writes to it are ignored.
- R10: A control write that keeps the run enable at 1 but changes bit 2 reloads the count from the reload value.
- R11: The reload (offset 0x4) and current words keep 24 bits, and their upper 8 bits read zero. Unmapped offsets read zero.
- R12: `irq_pulse` is never high for two cycles in a row and is only high in the cycle after an expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Byte offset of the register word |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| ref_tick | input | 1 | One-cycle reference step enable |
| irq_pulse | output | 1 | One-cycle interrupt request on expiry |

## Verification
A register write takes effect at the clock edge that samples it. A read answer is due one edge after the strobe. An expiry caused by the step event at edge N shows `irq_pulse` high between edges N and N+1, and low again after N+1. The bench drives strobes and `ref_tick` on the falling edge and samples on the following falling edge, so every check falls in the half-cycle after the edge that produces the result. Period sweeps count falling edges between successive pulses and compare the count with reload+1 step events, or three times that when the reference tick comes every third cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned OFS_CTRL    = 0;
  localparam int unsigned OFS_RELOAD  = 4;
  localparam int unsigned OFS_CURRENT = 8;
  localparam int unsigned OFS_CAL     = 12;

  localparam int unsigned CB_RUN   = 0;
  localparam int unsigned CB_IRQEN = 1;
  localparam int unsigned CB_SRC   = 2;
  localparam int unsigned CB_FLAG  = 16;

  typedef struct packed {
    logic src;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             use_core,
  input  logic             ref_tick,
  input  logic             force_load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;

  assign step   = run & (use_core | ref_tick);
  assign expire = step & ~force_load & (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (force_load) begin
      count <= reload_val;
    end else if (step) begin
      if (count == '0) count <= reload_val;
      else             count <= count - ONE;
    end
  end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_pulse,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              flag_q,
  output logic              force_load
);
  logic hit_ctrl, hit_reload, hit_cur, hit_cal;
  logic wr_ctrl, wr_reload, wr_cur, rd_ctrl, src_swap;
  logic [DATA_W-1:0] rd_value;
  logic unused_upper;

  assign hit_ctrl   = (addr == ADDR_W'(OFS_CTRL));
  assign hit_reload = (addr == ADDR_W'(OFS_RELOAD));
  assign hit_cur    = (addr == ADDR_W'(OFS_CURRENT));
  assign hit_cal    = (addr == ADDR_W'(OFS_CAL));

  assign wr_ctrl   = wr_en & hit_ctrl;
  assign wr_reload = wr_en & hit_reload;
  assign wr_cur    = wr_en & hit_cur;
  assign rd_ctrl   = rd_en & hit_ctrl;

  assign src_swap   = wr_ctrl & ctrl_q.run & wr_data[CB_RUN] &
                      (wr_data[CB_SRC] != ctrl_q.src);
  assign force_load = wr_cur | src_swap;

  assign unused_upper = ^wr_data[DATA_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run    <= wr_data[CB_RUN];
      ctrl_q.irq_en <= wr_data[CB_IRQEN];
      ctrl_q.src    <= wr_data[CB_SRC];
    end else if (expire && reload_q == '0) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    flag_q <= 1'b0;
    else if (expire)            flag_q <= 1'b1;
    else if (wr_cur || rd_ctrl) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)            reload_q <= '0;
    else if (wr_reload) reload_q <= wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_pulse <= 1'b0;
    else     irq_pulse <= expire & ctrl_q.irq_en;
  end

  always_comb begin
    rd_value = '0;
    if (hit_ctrl) begin
      rd_value[CB_RUN]   = ctrl_q.run;
      rd_value[CB_IRQEN] = ctrl_q.irq_en;
      rd_value[CB_SRC]   = ctrl_q.src;
      rd_value[CB_FLAG]  = flag_q;
    end else if (hit_reload) begin
      rd_value = DATA_W'(reload_q);
    end else if (hit_cur) begin
      rd_value = ctrl_q.run ? DATA_W'(count) : '0;
    end else if (hit_cal) begin
      rd_value = DATA_W'(CAL_VALUE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_value;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned CAL_VALUE = 10000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_tick,
  output logic              irq_pulse
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             expire_w;
  logic             force_w;
  logic             flag_q;

  tick_timer_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CAL_VALUE(CAL_VALUE)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .count(count_q), .expire(expire_w), .rd_data(rd_data),
    .irq_pulse(irq_pulse), .ctrl_q(ctrl_q), .reload_q(reload_q),
    .flag_q(flag_q), .force_load(force_w)
  );

  tick_timer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .use_core(ctrl_q.src),
    .ref_tick(ref_tick), .force_load(force_w), .reload_val(reload_q),
    .count(count_q), .expire(expire_w)
  );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_pulse,
  input logic              expire,
  input logic              run,
  input logic              flag,
  input logic              force_load,
  input logic [CNT_W-1:0]  reload_val,
  input logic [CNT_W-1:0]  count
);
  logic wide_read_q;

  always_ff @(posedge clk) begin
    if (rst) wide_read_q <= 1'b0;
    else     wide_read_q <= rd_en && (addr == ADDR_W'(OFS_RELOAD) ||
                                      addr == ADDR_W'(OFS_CURRENT));
  end

  a_r5_flag_after_expiry: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);

  a_r12_irq_from_expiry: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(expire));

  a_r12_irq_single_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);

  a_r6_zero_reload_halts: assert property (@(posedge clk) disable iff (rst)
    (expire && reload_val == '0 && !(wr_en && addr == ADDR_W'(OFS_CTRL))) |=> !run);

  a_r8_hold_while_off: assert property (@(posedge clk) disable iff (rst)
    (!run && !force_load) |=> $stable(count));

  a_r7_current_write_loads: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFS_CURRENT)) |=> (count == $past(reload_val) && !flag));

  a_r11_upper_bits_zero: assert property (@(posedge clk) disable iff (rst)
    wide_read_q |-> ((rd_data >> CNT_W) == '0));
endmodule

bind tick_timer tick_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rd_data(rd_data), .irq_pulse(irq_pulse), .expire(expire_w),
  .run(ctrl_q.run), .flag(flag_q), .force_load(force_w),
  .reload_val(reload_q), .count(count_q)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_RLD  = 4'h4;
  localparam logic [3:0] A_CUR  = 4'h8;
  localparam logic [3:0] A_CAL  = 4'hC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        ref_tick = 1'b0;
  logic        irq_pulse;

  int n_checks = 0;
  int n_fails  = 0;
  int phase    = 0;
  bit ref_auto = 1'b0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  tick_timer uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ref_tick(ref_tick), .irq_pulse(irq_pulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_ref();
    @(negedge clk);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      if (ref_auto) begin
        ref_tick = (phase % 3 == 0);
        phase++;
      end
      cyc++;
    end while (!irq_pulse && cyc < 5000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq after reset", {31'd0, irq_pulse}, 32'd0);
    rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
    rd(A_RLD, v);  check("R1 reload", v, 32'd0);
    rd(A_CUR, v);  check("R1 current", v, 32'd0);

    // R11 width and unmapped
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, v); check("R11 reload upper zero", v, 32'h00FF_FFFF);
    rd(4'h1, v);  check("R11 unmapped", v, 32'd0);

    // R9 calibration
    rd(A_CAL, v); check("R9 cal", v, 32'd10000);
    wr(A_CAL, 32'd5);
    rd(A_CAL, v); check("R9 cal write ignored", v, 32'd10000);

    // R2 field mapping
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, v); check("R2 only low bits written", v, 32'd0);
    wr(A_CTRL, 32'h6);
    rd(A_CTRL, v); check("R2 irq_en and src", v, 32'h6);
    wr(A_CTRL, 32'h0);

    // R8 / R4 / R7 in reference mode
    wr(A_RLD, 32'd5);
    wr(A_CUR, 32'hABCD);
    rd(A_CUR, v); check("R8 current zero when off", v, 32'd0);
    wr(A_CTRL, 32'h1);
    rd(A_CUR, v); check("R7 load while off", v, 32'd5);
    pulse_ref();
    rd(A_CUR, v); check("R4 one ref step", v, 32'd4);
    wr(A_CTRL, 32'h0);
    pulse_ref();
    wr(A_CTRL, 32'h1);
    rd(A_CUR, v); check("R8 count held", v, 32'd4);

    // R5 / R3 expiry with interrupt
    wr(A_CTRL, 32'h3);
    repeat (3) pulse_ref();
    rd(A_CUR, v); check("R4 count at one", v, 32'd1);
    pulse_ref();
    check("R5 irq high after expiry", {31'd0, irq_pulse}, 32'd1);
    @(negedge clk);
    check("R12 irq one cycle", {31'd0, irq_pulse}, 32'd0);
    rd(A_CTRL, v); check("R3 flag read", v, 32'h0001_0003);
    rd(A_CTRL, v); check("R3 flag cleared by read", v, 32'h3);
    pulse_ref();
    rd(A_CUR, v); check("R4 reload from zero", v, 32'd5);

    // R7 current write clears flag
    repeat (5) pulse_ref();
    wr(A_CUR, 32'h1234);
    rd(A_CTRL, v); check("R7 flag cleared", v, 32'h3);
    rd(A_CUR, v);  check("R7 reloaded", v, 32'd5);

    // R10 source change while running
    wr(A_CTRL, 32'h7);
    repeat (20) @(negedge clk);
    wr(A_RLD, 32'd1000);
    wr(A_CTRL, 32'h1);
    rd(A_CUR, v); check("R10 reload on source change", v, 32'd1000);

    // R5 no interrupt when disabled
    wr(A_RLD, 32'd2);
    wr(A_CUR, 32'd0);
    pulse_ref();
    pulse_ref();
    check("R5 no irq when irq_en=0", {31'd0, irq_pulse}, 32'd0);
    rd(A_CTRL, v); check("R5 flag without irq", v, 32'h0001_0001);

    // R6 zero reload one-shot
    wr(A_RLD, 32'd1);
    wr(A_CUR, 32'd0);
    wr(A_RLD, 32'd0);
    pulse_ref();
    rd(A_CTRL, v); check("R6 run cleared", v, 32'h0001_0000);
    rd(A_CUR, v);  check("R6 current reads zero", v, 32'd0);
    pulse_ref();
    rd(A_CTRL, v); check("R6 stays stopped", v, 32'd0);

    // R4 / R12 core-clock period sweep
    for (int r = 1; r <= 8; r++) begin
      wr(A_CTRL, 32'h0);
      wr(A_RLD, r);
      wr(A_CUR, 32'd0);
      wr(A_CTRL, 32'h7);
      wait_irq(c);
      wait_irq(c);
      check($sformatf("R4 core period reload %0d", r), c, r + 1);
      @(negedge clk);
      check("R12 irq single cycle", {31'd0, irq_pulse}, 32'd0);
    end

    // R4 reference-tick period sweep
    for (int r = 1; r <= 4; r++) begin
      wr(A_CTRL, 32'h0);
      wr(A_RLD, r);
      wr(A_CUR, 32'd0);
      wr(A_CTRL, 32'h3);
      ref_auto = 1'b1;
      wait_irq(c);
      wait_irq(c);
      ref_auto = 1'b0;
      ref_tick = 1'b0;
      check($sformatf("R4 ref period reload %0d", r), c, 3 * (r + 1));
    end
    wr(A_CTRL, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule